// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit settles control transfers for an in-order pipeline that has one delay slot after every branch and jump. Each cycle it takes the address of the transfer instruction, two register operands, the 16-bit immediate, the 26-bit jump index, a destination register field and a 4-bit transfer kind. It reports whether control moves, the address fetch continues from after the delay slot, and whether a return address is written, to which register and with what value.

Two operand-equality tests, four signed tests of the first operand against zero, an unconditional relative branch, absolute jumps that stay inside the current 256 MB region, and register-indirect jumps are supported. Linking forms write the address two instructions past the transfer, because the instruction in the delay slot always executes. Every result is registered once, so the outputs show the inputs sampled at the previous rising clock edge. Fetch, hazard handling and slot squashing belong to the surrounding pipeline.

Top module: `branch_resolve`

## Requirements
- R1: While rst_n is low, every output is held at zero.
- R2: Kind 1 moves control when op_a equals op_b and kind 2 when they differ. The target is pc + 4 plus the immediate shifted left by two and sign-extended from 18 bits.
- R3: Kinds 3, 4, 5 and 6 treat op_a as signed and move control when it is ≥ 0, > 0, ≤ 0 and < 0 respectively. The target is the same as in R2.
- R4: Kinds 7 (op_a ≥ 0) and 8 (op_a < 0) are the linking zero tests. They write pc + 8 into register 31 whether or not control moves.
- R5: Kinds 10 and 11 always move control to {pc[31:28], index, 2'b00}. Kind 11 also writes pc + 8 into register 31.
- R6: Kinds 12 and 13 always move control to op_a. Kind 13 also writes pc + 8 into the register named by dst.
- R7: A conditional kind (1 to 8) whose test fails reports not taken with next_pc = pc + 8. Kinds 0, 14 and 15 report not taken, next_pc = pc + 4 and no link.
- R8: Kind 9 always moves control to the relative target of R2 and writes no link.
- R9: The outputs change only at a rising clock edge, one cycle after the inputs they reflect.
- R10: Kinds without a link hold link_en, link_idx and link_val at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 32 | Address of the transfer instruction |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Branch immediate, in words |
| index | input | 26 | Jump index, in words |
| dst | input | 5 | Destination register for the register jump with link |
| kind | input | 4 | Transfer kind code |
| taken | output | 1 | Control moves to the target |
| next_pc | output | 32 | Address fetch continues from after the delay slot |
| link_en | output | 1 | Write the return address |
| link_idx | output | 5 | Register that receives the return address |
| link_val | output | 32 | Return address |

## Verification
On every cycle the assertions check the result against the inputs of the cycle before: the link value and register, region preservation and word alignment for absolute jumps, register-jump targets, the pc + 8 skip on a failed test, and the quiet state for unused kinds. Only the bench sweep shows that each signed zero test picks the right side of the boundary values 0, 1, -1, the most negative and the most positive operand. Only the sweep shows that the immediate sign-extends correctly at 0x7fff and 0x8000 and that a region stays fixed near the top of the address space.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

    typedef enum logic [3:0] {
        K_NONE     = 4'd0,
        K_EQ       = 4'd1,
        K_NE       = 4'd2,
        K_GEZ      = 4'd3,
        K_GTZ      = 4'd4,
        K_LEZ      = 4'd5,
        K_LTZ      = 4'd6,
        K_GEZ_LNK  = 4'd7,
        K_LTZ_LNK  = 4'd8,
        K_ALWAYS   = 4'd9,
        K_JUMP     = 4'd10,
        K_JUMP_LNK = 4'd11,
        K_REG      = 4'd12,
        K_REG_LNK  = 4'd13
    } xfer_kind_e;

    typedef struct packed {
        logic        taken;
        logic [31:0] next_pc;
        logic        link_en;
        logic [4:0]  link_idx;
        logic [31:0] link_val;
    } xfer_res_t;

endpackage

// File: rtl/branch_cond.sv
module branch_cond
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            is_cond,
    output logic            pass
);
    logic same;
    logic zero;
    logic neg;

    always_comb begin
        same    = (op_a == op_b);
        zero    = (op_a == '0);
        neg     = op_a[XLEN-1];
        is_cond = 1'b1;
        pass    = 1'b0;
        case (kind)
            K_EQ:                 pass = same;
            K_NE:                 pass = !same;
            K_GEZ, K_GEZ_LNK:     pass = !neg;
            K_GTZ:                pass = !neg && !zero;
            K_LEZ:                pass = neg || zero;
            K_LTZ, K_LTZ_LNK:     pass = neg;
            default:              is_cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  op_a,
    input  logic [IMM_W-1:0] imm,
    input  logic [IDX_W-1:0] index,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  skip_pc,
    output logic [XLEN-1:0]  rel_pc,
    output logic [XLEN-1:0]  abs_pc,
    output logic [XLEN-1:0]  reg_pc
);
    localparam int OFF_W = IMM_W + 2;
    localparam int EXT_W = XLEN - OFF_W;
    localparam int RGN_W = XLEN - IDX_W - 2;

    logic [XLEN-1:0] disp;

    always_comb begin
        disp    = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        seq_pc  = pc + XLEN'(4);
        skip_pc = pc + XLEN'(8);
        rel_pc  = seq_pc + disp;
        abs_pc  = {pc[XLEN-1 -: RGN_W], index, 2'b00};
        reg_pc  = op_a;
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IMM_W    = 16,
    parameter int IDX_W    = 26,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  index,
    input  logic [RIDX_W-1:0] dst,
    input  logic [3:0]        kind,
    output logic              taken,
    output logic [XLEN-1:0]   next_pc,
    output logic              link_en,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val
);
    localparam int RGN_W = XLEN - IDX_W - 2;

    logic            is_cond;
    logic            pass;
    logic [XLEN-1:0] seq_pc, skip_pc, rel_pc, abs_pc, reg_pc;

    typedef struct packed {
        logic              taken;
        logic [XLEN-1:0]   next_pc;
        logic              link_en;
        logic [RIDX_W-1:0] link_idx;
        logic [XLEN-1:0]   link_val;
    } res_t;

    res_t res_d, res_q;

    branch_cond #(.XLEN(XLEN)) u_cond (
        .kind    (kind),
        .op_a    (op_a),
        .op_b    (op_b),
        .is_cond (is_cond),
        .pass    (pass)
    );

    branch_target #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_tgt (
        .pc      (pc),
        .op_a    (op_a),
        .imm     (imm),
        .index   (index),
        .seq_pc  (seq_pc),
        .skip_pc (skip_pc),
        .rel_pc  (rel_pc),
        .abs_pc  (abs_pc),
        .reg_pc  (reg_pc)
    );

    always_comb begin
        res_d         = '0;
        res_d.next_pc = seq_pc;
        if (is_cond) begin
            res_d.taken   = pass;
            res_d.next_pc = pass ? rel_pc : skip_pc;
        end
        case (kind)
            K_ALWAYS: begin
                res_d.taken   = 1'b1;
                res_d.next_pc = rel_pc;
            end
            K_JUMP, K_JUMP_LNK: begin
                res_d.taken   = 1'b1;
                res_d.next_pc = abs_pc;
            end
            K_REG, K_REG_LNK: begin
                res_d.taken   = 1'b1;
                res_d.next_pc = reg_pc;
            end
            default: ;
        endcase
        case (kind)
            K_GEZ_LNK, K_LTZ_LNK, K_JUMP_LNK: begin
                res_d.link_en  = 1'b1;
                res_d.link_idx = RIDX_W'(LINK_REG);
                res_d.link_val = skip_pc;
            end
            K_REG_LNK: begin
                res_d.link_en  = 1'b1;
                res_d.link_idx = dst;
                res_d.link_val = skip_pc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign taken    = res_q.taken;
    assign next_pc  = res_q.next_pc;
    assign link_en  = res_q.link_en;
    assign link_idx = res_q.link_idx;
    assign link_val = res_q.link_val;

    p_link_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && link_en) |-> (link_val == $past(pc) + XLEN'(8)));

    p_link_fixed_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(kind) == K_JUMP_LNK || $past(kind) == K_GEZ_LNK
                          || $past(kind) == K_LTZ_LNK))
        |-> (link_en && link_idx == RIDX_W'(LINK_REG)));

    p_region_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(kind) == K_JUMP || $past(kind) == K_JUMP_LNK))
        |-> (taken && next_pc[XLEN-1 -: RGN_W] == $past(pc[XLEN-1 -: RGN_W])
             && next_pc[1:0] == 2'b00));

    p_reg_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(kind) == K_REG || $past(kind) == K_REG_LNK))
        |-> (taken && next_pc == $past(op_a)));

    p_skip_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind) >= 4'd1 && $past(kind) <= 4'd8 && !taken)
        |-> (next_pc == $past(pc) + XLEN'(8)));

    p_quiet_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(kind) == 4'd0 || $past(kind) >= 4'd14))
        |-> (!taken && !link_en && link_val == '0));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (!taken && !link_en && next_pc == '0));
endmodule

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0, op_a = '0, op_b = '0;
    logic [15:0] imm = '0;
    logic [25:0] index = '0;
    logic [4:0]  dst = '0;
    logic [3:0]  kind = '0;
    logic        taken, link_en;
    logic [31:0] next_pc, link_val;
    logic [4:0]  link_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_resolve u_branch_resolve (
        .clk(clk), .rst_n(rst_n), .pc(pc), .op_a(op_a), .op_b(op_b),
        .imm(imm), .index(index), .dst(dst), .kind(kind),
        .taken(taken), .next_pc(next_pc), .link_en(link_en),
        .link_idx(link_idx), .link_val(link_val)
    );

    function automatic logic [70:0] model(input logic [3:0] k, input logic [31:0] p,
            input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
            input logic [25:0] ix, input logic [4:0] d);
        logic        t = 1'b0, we = 1'b0;
        logic [31:0] n = p + 32'd4, v = '0;
        logic [4:0]  r = '0;
        logic [31:0] rel = p + 32'd4 + (32'($signed(im)) * 32'd4);
        logic        c = 1'b0;
        bit          cond = (k >= 4'd1 && k <= 4'd8);
        case (k)
            4'd1: c = (a == b);
            4'd2: c = (a != b);
            4'd3, 4'd7: c = ($signed(a) >= 0);
            4'd4: c = ($signed(a) > 0);
            4'd5: c = ($signed(a) <= 0);
            4'd6, 4'd8: c = ($signed(a) < 0);
            default: c = 1'b0;
        endcase
        if (cond) begin t = c; n = c ? rel : p + 32'd8; end
        if (k == 4'd9) begin t = 1'b1; n = rel; end
        if (k == 4'd10 || k == 4'd11) begin t = 1'b1; n = (p & 32'hF000_0000) | (32'(ix) * 32'd4); end
        if (k == 4'd12 || k == 4'd13) begin t = 1'b1; n = a; end
        if (k == 4'd7 || k == 4'd8 || k == 4'd11) begin we = 1'b1; r = 5'd31; v = p + 32'd8; end
        if (k == 4'd13) begin we = 1'b1; r = d; v = p + 32'd8; end
        return {t, n, we, r, v};
    endfunction

    function automatic string tag(input logic [3:0] k, input logic [70:0] e);
        if (k == 4'd0 || k >= 4'd14) return "R7/R10";
        if (k <= 4'd8 && !e[70]) return "R7";
        if (k <= 4'd2) return "R2";
        if (k <= 4'd6) return "R3";
        if (k <= 4'd8) return "R4";
        if (k == 4'd9) return "R8";
        if (k <= 4'd11) return "R5";
        return "R6";
    endfunction

    task automatic check(input string t, input logic [70:0] exp);
        logic [70:0] got = {taken, next_pc, link_en, link_idx, link_val};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", t, got, exp);
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pcs [4]  = '{32'h0000_0100, 32'h7FFF_FFF8, 32'hF000_0000, 32'hFFFF_FFF0};
        logic [31:0] as  [6]  = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'd5};
        logic [15:0] ims [5]  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        logic [70:0] prev = '0;
        bit have = 1'b0;

        repeat (3) @(negedge clk);
        check("R1", '0);   // R1: cleared under reset
        rst_n = 1'b1;

        for (int pi = 0; pi < 4; pi++)
        for (int k = 0; k < 16; k++)
        for (int ai = 0; ai < 6; ai++)
        for (int bi = 0; bi < 3; bi++)
        for (int mi = 0; mi < 5; mi++) begin
            @(negedge clk);
            if (have) check(tag(kind, prev), prev);
            pc    = pcs[pi];
            op_a  = as[ai];
            op_b  = (bi == 0) ? as[ai] : (bi == 1) ? 32'h0 : ~as[ai];
            imm   = ims[mi];
            index = {ims[mi], ims[(mi + 2) % 5][9:0]};
            dst   = 5'(ai * 5 + bi + 1);
            kind  = 4'(k);
            #1;
            if (have) check("R9", prev);   // R9: new inputs not yet visible
            prev = model(kind, pc, op_a, op_b, imm, index, dst);
            have = 1'b1;
        end
        @(negedge clk);
        check(tag(kind, prev), prev);

        rst_n = 1'b0;
        #1;
        check("R1", '0);   // R1: asynchronous clear mid-run
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule